// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block handles exception entry and exception return for a small 32-bit load/store processor core. Seven request lines come in from the rest of the core: a reset request, an undefined-instruction trap, a supervisor call, an instruction-fetch abort, a data-access abort, a normal interrupt and a fast interrupt. When a request is accepted, the block does four things in the same clock edge. It copies the current status word into the saved-status register of the mode being entered. It writes a return address, derived from the captured fetch address, into that mode's link register. It rewrites the status word. It emits a program-counter load to the vector slot of the exception.

A return command reverses the entry. The status word comes back from the current mode's saved-status register, and the program counter is reloaded from that mode's link register. Each exception mode also has its own banked stack pointer, which the datapath writes and reads through the block. The vector base is either all zeros or a high base, and a configuration input chooses between them.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset the status word is 0x000000D3. That is supervisor mode 10011 in bits [4:0], the state bit (bit 5) at 0, the fast-interrupt disable (bit 6) at 1 and the interrupt disable (bit 7) at 1. `pc_load` and `ret_err` are 0, and every banked link and stack register reads 0.
- R2: `exc_req` carries one request per bit: bit 0 reset, 1 undefined instruction, 2 supervisor call, 3 fetch abort, 4 data abort, 5 interrupt, 6 fast interrupt. These use vector slots 0, 1, 2, 3, 4, 6 and 7 in that bit order. The vector address is base + 4*slot, where the base is 0x00000000 when `hi_vectors` is 0 and `HI_BASE` (default 0xFFFF0000) when it is 1.
- R3: When several requests are pending at once, they are served in this order: reset, data abort, fast interrupt, interrupt, fetch abort, undefined instruction, supervisor call.
- R4: A request sampled at a rising edge shows at the outputs right after that edge. `pc_load` is high for that one cycle, with `pc_target` set to the vector address.
- R5: On entry the status word keeps bits [31:8] and the mode field takes the target mode. The target modes are: fast interrupt 10001, interrupt 10010, reset and supervisor call 10011, both aborts 10111, undefined 11011. Bit 5 is cleared and bit 7 is set. Bit 6 is set only for reset and fast interrupt, and keeps its value otherwise.
- R6: On entry, the status word as it was before the edge is saved in the saved-status register of the target mode.
- R7: On entry, the target mode's link register receives `fetch_pc` for a data abort and `fetch_pc - 4` for every other exception. A reset request writes no link register. `lr_cur` shows the link register of the current mode, and 0 in user mode.
- R8: An interrupt request is ignored while bit 7 of the status word is set. A fast-interrupt request is ignored while bit 6 is set. The next unmasked request is taken instead. Reset is never masked.
- R9: A return command in a mode that has a saved-status register loads the status word from that register and pulses `pc_load` with the mode's link register as `pc_target`, one cycle later.
- R10: A return command in user mode, or in any mode encoding with no bank, leaves the status word unchanged and gives no `pc_load`. Instead it pulses `ret_err` for one cycle.
- R11: The stack pointer is banked per mode, with one bank for user mode and one for each exception mode. `sp_wr_en` writes the bank of the current mode, and `sp_cur` shows that bank.
- R12: An accepted request takes precedence over a return command and over a status write in the same cycle. A return command takes precedence over a status write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 7 | Exception request lines, bit layout as in R2 |
| hi_vectors | input | 1 | Selects the high vector base |
| fetch_pc | input | 32 | Captured program counter used to form the link address |
| ret_cmd | input | 1 | Exception-return command |
| psr_wr_en | input | 1 | Status-word write from the datapath |
| psr_wdata | input | 32 | Status-word write data |
| sp_wr_en | input | 1 | Write enable for the current mode's stack pointer |
| sp_wdata | input | 32 | Stack pointer write data |
| psr | output | 32 | Current status word |
| pc_load | output | 1 | One-cycle program-counter load strobe |
| pc_target | output | 32 | Program-counter load address |
| lr_cur | output | 32 | Link register of the current mode |
| sp_cur | output | 32 | Stack pointer of the current mode |
| ret_err | output | 1 | One-cycle flag for a return with no saved status |

## Verification
A corrupted saved-status or link entry stays hidden until the matching return. At that point it shows up as a wrong `psr` or `pc_target` in the cycle after the return command. The bench therefore pairs every entry with a return, including nested entries. A wrong bank index shows sooner: `lr_cur` and `sp_cur` read the wrong bank in the first cycle after the mode changes. A wrong priority or mask decision shows up as a wrong vector on `pc_target` in the cycle after the request.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

  localparam int XLEN   = 32;
  localparam int NREQ   = 7;
  localparam int NBANK  = 6;
  localparam int BANK_W = $clog2(NBANK);

  // status word bit positions
  localparam int PSR_T = 5;
  localparam int PSR_F = 6;
  localparam int PSR_I = 7;

  // request line indices
  localparam int RQ_RESET = 0;
  localparam int RQ_UNDEF = 1;
  localparam int RQ_SVC   = 2;
  localparam int RQ_PABT  = 3;
  localparam int RQ_DABT  = 4;
  localparam int RQ_IRQ   = 5;
  localparam int RQ_FIQ   = 6;

  typedef enum logic [2:0] {
    SLOT_RESET = 3'd0,
    SLOT_UNDEF = 3'd1,
    SLOT_SVC   = 3'd2,
    SLOT_PABT  = 3'd3,
    SLOT_DABT  = 3'd4,
    SLOT_RSVD  = 3'd5,
    SLOT_IRQ   = 3'd6,
    SLOT_FIQ   = 3'd7
  } slot_e;

  localparam logic [4:0] MODE_USR = 5'b10000;
  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_IRQ = 5'b10010;
  localparam logic [4:0] MODE_SVC = 5'b10011;
  localparam logic [4:0] MODE_ABT = 5'b10111;
  localparam logic [4:0] MODE_UND = 5'b11011;

  localparam logic [XLEN-1:0] PSR_AT_RESET = 32'h0000_00D3;

  function automatic slot_e req_slot(input int idx);
    case (idx)
      RQ_RESET: return SLOT_RESET;
      RQ_UNDEF: return SLOT_UNDEF;
      RQ_SVC:   return SLOT_SVC;
      RQ_PABT:  return SLOT_PABT;
      RQ_DABT:  return SLOT_DABT;
      RQ_IRQ:   return SLOT_IRQ;
      default:  return SLOT_FIQ;
    endcase
  endfunction

  function automatic logic [4:0] slot_mode(input slot_e s);
    case (s)
      SLOT_FIQ:             return MODE_FIQ;
      SLOT_IRQ:             return MODE_IRQ;
      SLOT_UNDEF:           return MODE_UND;
      SLOT_PABT, SLOT_DABT: return MODE_ABT;
      default:              return MODE_SVC;
    endcase
  endfunction

  // bank 0 belongs to user mode and holds no saved status
  function automatic logic [BANK_W-1:0] mode_bank(input logic [4:0] m);
    case (m)
      MODE_FIQ: return BANK_W'(1);
      MODE_IRQ: return BANK_W'(2);
      MODE_SVC: return BANK_W'(3);
      MODE_ABT: return BANK_W'(4);
      MODE_UND: return BANK_W'(5);
      default:  return BANK_W'(0);
    endcase
  endfunction

  // distance between the captured fetch address and the resume point
  function automatic logic [XLEN-1:0] link_adjust(input slot_e s);
    return (s == SLOT_DABT) ? '0 : XLEN'(4);
  endfunction

  function automatic logic [XLEN-1:0] vector_addr(input logic hi,
                                                  input logic [XLEN-1:0] hi_base,
                                                  input slot_e s);
    logic [XLEN-1:0] base;
    base = hi ? hi_base : '0;
    return base + {{(XLEN-5){1'b0}}, s, 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] psr_on_entry(input logic [XLEN-1:0] old,
                                                   input slot_e s);
    logic [XLEN-1:0] n;
    n        = old;
    n[4:0]   = slot_mode(s);
    n[PSR_T] = 1'b0;
    n[PSR_I] = 1'b1;
    if (s == SLOT_RESET || s == SLOT_FIQ) n[PSR_F] = 1'b1;
    return n;
  endfunction

endpackage

// File: rtl/exc_prio_arb.sv
module exc_prio_arb
  import exc_seq_pkg::*;
(
  input  logic [NREQ-1:0] req,
  input  logic            irq_masked,
  input  logic            fiq_masked,
  output logic            hit,
  output slot_e           slot
);

  // highest priority first
  localparam int PRIO [NREQ] = '{RQ_RESET, RQ_DABT, RQ_FIQ, RQ_IRQ,
                                 RQ_PABT, RQ_UNDEF, RQ_SVC};

  logic [NREQ-1:0] eff;
  logic [NREQ-1:0] grant;

  always_comb begin
    eff          = req;
    eff[RQ_IRQ]  = req[RQ_IRQ] & ~irq_masked;
    eff[RQ_FIQ]  = req[RQ_FIQ] & ~fiq_masked;
    grant        = '0;
    slot         = SLOT_RESET;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (eff[PRIO[i]]) begin
        grant          = '0;
        grant[PRIO[i]] = 1'b1;
        slot           = req_slot(PRIO[i]);
      end
    end
    hit = |eff;
  end

  always_comb begin
    a_r3_single_grant: assert ($onehot0(grant));
    a_r8_irq_mask_held: assert (!(irq_masked && grant[RQ_IRQ]));
    a_r8_fiq_mask_held: assert (!(fiq_masked && grant[RQ_FIQ]));
  end

endmodule

// File: rtl/exc_bank_regs.sv
module exc_bank_regs #(
  parameter int DEPTH = 6,
  parameter int WIDTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_idx,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en && (int'(wr_idx) < DEPTH)) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_data = (int'(rd_idx) < DEPTH) ? mem[rd_idx] : '0;

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter logic [31:0] HI_BASE = 32'hFFFF_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [6:0]  exc_req,
  input  logic        hi_vectors,
  input  logic [31:0] fetch_pc,
  input  logic        ret_cmd,
  input  logic        psr_wr_en,
  input  logic [31:0] psr_wdata,
  input  logic        sp_wr_en,
  input  logic [31:0] sp_wdata,
  output logic [31:0] psr,
  output logic        pc_load,
  output logic [31:0] pc_target,
  output logic [31:0] lr_cur,
  output logic [31:0] sp_cur,
  output logic        ret_err
);

  logic [XLEN-1:0]   psr_q, pc_target_q;
  logic              pc_load_q, ret_err_q;

  logic              take;
  slot_e             slot;
  logic [4:0]        tgt_mode;
  logic [BANK_W-1:0] cur_bank, tgt_bank;
  logic              ret_ok, ret_bad;
  logic [XLEN-1:0]   spsr_rd, lr_rd, link_val;

  exc_prio_arb u_arb (
    .req        (exc_req),
    .irq_masked (psr_q[PSR_I]),
    .fiq_masked (psr_q[PSR_F]),
    .hit        (take),
    .slot       (slot)
  );

  assign tgt_mode = slot_mode(slot);
  assign tgt_bank = mode_bank(tgt_mode);
  assign cur_bank = mode_bank(psr_q[4:0]);
  assign ret_ok   = ret_cmd && !take && (cur_bank != '0);
  assign ret_bad  = ret_cmd && !take && (cur_bank == '0);
  assign link_val = fetch_pc - link_adjust(slot);

  exc_bank_regs #(.DEPTH(NBANK), .WIDTH(XLEN)) u_spsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (take),
    .wr_idx  (tgt_bank),
    .wr_data (psr_q),
    .rd_idx  (cur_bank),
    .rd_data (spsr_rd)
  );

  exc_bank_regs #(.DEPTH(NBANK), .WIDTH(XLEN)) u_link (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (take && (slot != SLOT_RESET)),
    .wr_idx  (tgt_bank),
    .wr_data (link_val),
    .rd_idx  (cur_bank),
    .rd_data (lr_rd)
  );

  exc_bank_regs #(.DEPTH(NBANK), .WIDTH(XLEN)) u_stack (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (sp_wr_en),
    .wr_idx  (cur_bank),
    .wr_data (sp_wdata),
    .rd_idx  (cur_bank),
    .rd_data (sp_cur)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psr_q       <= PSR_AT_RESET;
      pc_load_q   <= 1'b0;
      pc_target_q <= '0;
      ret_err_q   <= 1'b0;
    end else begin
      pc_load_q <= 1'b0;
      ret_err_q <= 1'b0;
      if (take) begin
        psr_q       <= psr_on_entry(psr_q, slot);
        pc_load_q   <= 1'b1;
        pc_target_q <= vector_addr(hi_vectors, HI_BASE, slot);
      end else if (ret_ok) begin
        psr_q       <= spsr_rd;
        pc_load_q   <= 1'b1;
        pc_target_q <= lr_rd;
      end else if (ret_bad) begin
        ret_err_q   <= 1'b1;
      end else if (psr_wr_en) begin
        psr_q       <= psr_wdata;
      end
    end
  end

  assign psr       = psr_q;
  assign pc_load   = pc_load_q;
  assign pc_target = pc_target_q;
  assign ret_err   = ret_err_q;
  assign lr_cur    = lr_rd;

  a_r4_entry_loads_pc: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (pc_load && !ret_err));

  a_r5_entry_state_bits: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!psr[PSR_T] && psr[PSR_I]));

  a_r2_vector_shape: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (((pc_target & ~32'h1C) == 32'h0) || ((pc_target & ~32'h1C) == HI_BASE)));

  a_r9_return_restores: assert property (@(posedge clk) disable iff (!rst_n)
    ret_ok |=> (pc_load && psr == $past(spsr_rd) && pc_target == $past(lr_rd)));

  a_r10_bad_return: assert property (@(posedge clk) disable iff (!rst_n)
    ret_bad |=> (ret_err && !pc_load && $stable(psr)));

  a_r8_fiq_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (psr[PSR_F] && exc_req == 7'h40 && !ret_cmd) |=> !pc_load);

endmodule

// File: tb/exc_entry_seq_test.sv
module exc_entry_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  exc_req = '0;
  logic        hi_vectors = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        ret_cmd = 1'b0;
  logic        psr_wr_en = 1'b0;
  logic [31:0] psr_wdata = '0;
  logic        sp_wr_en = 1'b0;
  logic [31:0] sp_wdata = '0;
  logic [31:0] psr, pc_target, lr_cur, sp_cur;
  logic        pc_load, ret_err;

  int total = 0;
  int fails = 0;

  // bench model of the architectural state
  logic [31:0] m_psr;
  logic [31:0] m_spsr [6];
  logic [31:0] m_lr   [6];
  logic [31:0] m_sp   [6];

  exc_entry_seq uut (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .hi_vectors(hi_vectors),
    .fetch_pc(fetch_pc), .ret_cmd(ret_cmd), .psr_wr_en(psr_wr_en),
    .psr_wdata(psr_wdata), .sp_wr_en(sp_wr_en), .sp_wdata(sp_wdata),
    .psr(psr), .pc_load(pc_load), .pc_target(pc_target), .lr_cur(lr_cur),
    .sp_cur(sp_cur), .ret_err(ret_err)
  );

  always #2 clk = ~clk;

  initial begin
    #(4 * 100000);
    fails++; total++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  function automatic int bank_of(input logic [4:0] m);
    case (m)
      5'b10001: return 1;
      5'b10010: return 2;
      5'b10011: return 3;
      5'b10111: return 4;
      5'b11011: return 5;
      default:  return 0;
    endcase
  endfunction

  // one cycle: drive at a falling edge, check at the next falling edge
  task automatic step(input logic [6:0] rq, input logic rc, input logic pwe,
                      input logic [31:0] pwd, input logic swe, input logic [31:0] swd,
                      input logic hv, input logic [31:0] fpc, input string tag);
    logic [6:0]  eff;
    logic [31:0] e_tgt;
    logic        e_load, e_err;
    int          k, b, nb, slotn;
    logic [4:0]  md;
    int          order [7] = '{0, 4, 6, 5, 3, 1, 2};
    exc_req = rq; ret_cmd = rc; psr_wr_en = pwe; psr_wdata = pwd;
    sp_wr_en = swe; sp_wdata = swd; hi_vectors = hv; fetch_pc = fpc;
    eff = rq;
    if (m_psr[7]) eff[5] = 1'b0;
    if (m_psr[6]) eff[6] = 1'b0;
    k = -1;
    for (int i = 6; i >= 0; i--) if (eff[order[i]]) k = order[i];
    b = bank_of(m_psr[4:0]);
    e_load = 1'b0; e_err = 1'b0; e_tgt = pc_target;
    if (swe) m_sp[b] = swd;
    if (k >= 0) begin
      case (k)
        0: begin md = 5'b10011; slotn = 0; end
        1: begin md = 5'b11011; slotn = 1; end
        2: begin md = 5'b10011; slotn = 2; end
        3: begin md = 5'b10111; slotn = 3; end
        4: begin md = 5'b10111; slotn = 4; end
        5: begin md = 5'b10010; slotn = 6; end
        default: begin md = 5'b10001; slotn = 7; end
      endcase
      nb = bank_of(md);
      m_spsr[nb] = m_psr;
      if (k != 0) m_lr[nb] = fpc - ((k == 4) ? 32'd0 : 32'd4);
      m_psr[4:0] = md;
      m_psr[5]   = 1'b0;
      m_psr[7]   = 1'b1;
      if (k == 0 || k == 6) m_psr[6] = 1'b1;
      e_load = 1'b1;
      e_tgt  = (hv ? 32'hFFFF_0000 : 32'h0) + 32'(slotn * 4);
    end else if (rc) begin
      if (b != 0) begin
        e_load = 1'b1;
        e_tgt  = m_lr[b];
        m_psr  = m_spsr[b];
      end else begin
        e_err = 1'b1;
      end
    end else if (pwe) begin
      m_psr = pwd;
    end
    @(negedge clk);
    exc_req = '0; ret_cmd = 1'b0; psr_wr_en = 1'b0; sp_wr_en = 1'b0;
    check(tag, "psr", psr, m_psr);
    check(tag, "pc_load", {31'b0, pc_load}, {31'b0, e_load});
    if (e_load) check(tag, "pc_target", pc_target, e_tgt);
    check("R10", "ret_err", {31'b0, ret_err}, {31'b0, e_err});
    check("R7", "lr_cur", lr_cur, m_lr[bank_of(m_psr[4:0])]);
    check("R11", "sp_cur", sp_cur, m_sp[bank_of(m_psr[4:0])]);
  endtask

  task automatic ent(input logic [6:0] rq, input logic hv, input logic [31:0] fpc,
                     input string tag);
    step(rq, 1'b0, 1'b0, '0, 1'b0, '0, hv, fpc, tag);
  endtask
  task automatic ret(input string tag);
    step('0, 1'b1, 1'b0, '0, 1'b0, '0, 1'b0, '0, tag);
  endtask
  task automatic pwr(input logic [31:0] v, input string tag);
    step('0, 1'b0, 1'b1, v, 1'b0, '0, 1'b0, '0, tag);
  endtask
  task automatic spw(input logic [31:0] v, input string tag);
    step('0, 1'b0, 1'b0, '0, 1'b1, v, 1'b0, '0, tag);
  endtask
  task automatic idle(input string tag);
    step('0, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0, '0, tag);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_psr = 32'h0000_00D3;
    for (int i = 0; i < 6; i++) begin
      m_spsr[i] = '0; m_lr[i] = '0; m_sp[i] = '0;
    end
    check("R1", "psr", psr, 32'h0000_00D3);
    check("R1", "pc_load", {31'b0, pc_load}, 32'h0);
    check("R1", "ret_err", {31'b0, ret_err}, 32'h0);
    check("R1", "lr_cur", lr_cur, 32'h0);
    check("R1", "sp_cur", sp_cur, 32'h0);
  endtask

  task automatic t_vectors(input logic hv);
    for (int k = 0; k < 7; k++) begin
      pwr(32'hA000_0010, "R5");
      ent(7'(1 << k), hv, 32'h0000_1000 + 32'(k * 16), "R2");
      idle("R4");
      ret("R6");
    end
  endtask

  task automatic t_priority;
    pwr(32'h0000_0010, "R3");
    ent(7'h7F, 1'b0, 32'h200, "R3"); ret("R9");
    ent(7'h7E, 1'b0, 32'h210, "R3"); ret("R9");
    ent(7'h6E, 1'b0, 32'h220, "R3"); ret("R9");
    ent(7'h2E, 1'b0, 32'h230, "R3"); ret("R9");
    ent(7'h0E, 1'b0, 32'h240, "R3"); ret("R9");
    ent(7'h06, 1'b0, 32'h250, "R3"); ret("R9");
    ent(7'h04, 1'b1, 32'h260, "R3"); ret("R9");
  endtask

  task automatic t_mask;
    pwr(32'h0000_0090, "R8");
    ent(7'h20, 1'b0, 32'h300, "R8");
    pwr(32'h0000_0050, "R8");
    ent(7'h40, 1'b0, 32'h310, "R8");
    pwr(32'h0000_00D0, "R8");
    ent(7'h62, 1'b0, 32'h320, "R8"); ret("R8");
    ent(7'h01, 1'b0, 32'h330, "R8"); ret("R8");
    pwr(32'h0000_0010, "R6");
    ent(7'h20, 1'b0, 32'h400, "R6");
    ent(7'h20, 1'b0, 32'h410, "R8");
    ent(7'h60, 1'b1, 32'h420, "R6");
    ret("R6");
    ret("R6");
  endtask

  task automatic t_bad_return;
    pwr(32'h0000_0010, "R10");
    ret("R10");
    idle("R10");
    pwr(32'h0000_001F, "R10");
    ret("R10");
  endtask

  task automatic t_stack;
    pwr(32'h0000_0010, "R11");
    spw(32'h0000_1111, "R11");
    ent(7'h20, 1'b0, 32'h500, "R11");
    spw(32'h0000_2222, "R11");
    ret("R11");
    ent(7'h20, 1'b0, 32'h504, "R11");
    ret("R11");
  endtask

  task automatic t_conflict;
    pwr(32'h0000_0010, "R12");
    step(7'h20, 1'b1, 1'b1, 32'h0000_001F, 1'b0, '0, 1'b0, 32'h600, "R12");
    step('0, 1'b1, 1'b1, 32'h0000_0013, 1'b0, '0, 1'b0, '0, "R12");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_vectors(1'b0);
    t_vectors(1'b1);
    t_priority();
    t_mask();
    t_bad_return();
    t_stack();
    t_conflict();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule